// File: doc/BRIEF.md
# Main Clock Source Selector with Update Latch

This block is a cycle-level model of the clock-source choice at the root of a small processor's clocking tree. Each candidate source appears as a one-cycle enable pulse on the block's fast reference clock: the internal RC oscillator, the system oscillator, the watchdog oscillator and the PLL output. Two select registers choose the main clock. One picks the PLL input, either the RC oscillator or the system oscillator, and that choice is also the "PLL input" candidate for the main clock. The other picks among RC, PLL input, watchdog and PLL output. A programmable divider then turns the main clock enable into the system clock enable.

Software writes a select register first. That only stages the new value. The choice takes effect when the matching update register sees a write of 0 followed by a write of 1. Software then polls bit 0 of the update register until it reads 1. The committed sources are brought out on status pins, so a testbench can see that a switch waits for this sequence.

Top module: `clk_src_sel`

## Requirements
- R1: After reset the committed main source is 0 (RC) and the committed PLL input is 0 (RC). Both update registers read 1, and the divider register reads 1.
- R2: The main-select codes are 0 = RC oscillator, 1 = PLL input, 2 = watchdog oscillator and 3 = PLL output. `main_ce` equals the enable of the committed source in the same cycle.
- R3: For the PLL input select, bit 0 = 1 picks the system oscillator and bit 0 = 0 picks the RC oscillator. `pll_in_ce` follows the committed choice.
- R4: Writing a select register (address 0 for the PLL input, address 2 for the main clock) leaves the committed source unchanged. The staged value is committed only by a write with bit 0 = 1 to the matching update register (address 1 or 3) while that register holds 0.
- R5: An update register reads back bit 0 of the last value written to it. After a write of 1 it reads 1 in the next cycle, and the newly committed source is then visible on the status pins.
- R6: Writing 1 to an update register that already holds 1 does not commit a newly staged value.
- R7: The divider register lives at address 4. For a divider value N between 1 and 255, `sys_ce` pulses on every Nth `main_ce` pulse, counted from reset or from the last divider write.
- R8: A divider value of 0 holds `sys_ce` low.
- R9: A divider value of 1 makes `sys_ce` equal to `main_ce`.
- R10: `rdata` returns the register at `addr` in the same cycle: 0 staged PLL-input select, 1 PLL update, 2 staged main select, 3 main update, 4 divider, and 0 for any other address. Unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock on which all source enables are sampled |
| rst_n | input | 1 | Active-low synchronous reset |
| irc_ce | input | 1 | Enable pulse of the internal RC oscillator |
| sysosc_ce | input | 1 | Enable pulse of the system oscillator |
| wdo_ce | input | 1 | Enable pulse of the watchdog oscillator |
| pllout_ce | input | 1 | Enable pulse of the PLL output |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| pll_in_ce | output | 1 | Enable pulse selected as the PLL input |
| main_ce | output | 1 | Main clock enable |
| sys_ce | output | 1 | Divided system clock enable |
| main_src | output | 2 | Committed main-source code |
| pll_src | output | 1 | Committed PLL-input code |

## Verification
`main_ce`, `pll_in_ce`, `sys_ce` and `rdata` are combinational functions of the inputs and the current registers, so they are due in the same cycle as the stimulus. A register write, including a committing update write, shows up on `main_src`, `pll_src` and the read data one clock edge later. The bench drives inputs at the falling edge and compares all outputs 1 ns later against a behavioural model. It advances that model only at the following rising edge, so every comparison sees exactly the state the design holds in that cycle.

// File: rtl/clk_src_sel_pkg.sv
package clk_src_sel_pkg;

  typedef enum logic [1:0] {
    MSRC_IRC    = 2'd0,
    MSRC_PLLIN  = 2'd1,
    MSRC_WDO    = 2'd2,
    MSRC_PLLOUT = 2'd3
  } main_src_e;

  localparam int unsigned MAIN_SEL_W = 2;
  localparam int unsigned PLL_SEL_W  = 1;

  // choose the enable of the committed main source
  function automatic logic pick_main(input logic [1:0] sel, input logic irc,
                                     input logic pllin, input logic wdo,
                                     input logic pllout);
    case (main_src_e'(sel))
      MSRC_IRC:    pick_main = irc;
      MSRC_PLLIN:  pick_main = pllin;
      MSRC_WDO:    pick_main = wdo;
      default:     pick_main = pllout;
    endcase
  endfunction

  // PLL input: code 1 = system oscillator, everything else = RC
  function automatic logic pick_pll_in(input logic sel, input logic irc,
                                       input logic sysosc);
    pick_pll_in = sel ? sysosc : irc;
  endfunction

  // true when the tick being counted completes a divide period
  function automatic logic div_wrap(input logic [7:0] cnt, input logic [7:0] div);
    div_wrap = (div != 8'd0) && ({1'b0, cnt} + 9'd1 >= {1'b0, div});
  endfunction

endpackage

// File: rtl/clk_src_stage.sv
module clk_src_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_we,
  input  logic         upd_we,
  input  logic [W-1:0] sel_wdata,
  input  logic         upd_wbit,
  output logic [W-1:0] staged,
  output logic [W-1:0] active,
  output logic         upd_q,
  output logic         commit
);

  // a commit needs a 1 written while the update bit holds 0
  assign commit = upd_we && upd_wbit && !upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= '0;
      active <= '0;
      upd_q  <= 1'b1;
    end else begin
      if (sel_we) staged <= sel_wdata;
      if (commit) active <= staged;
      if (upd_we) upd_q  <= upd_wbit;
    end
  end

endmodule

// File: rtl/clk_sys_div.sv
module clk_sys_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         div_we,
  input  logic [W-1:0] div_wdata,
  output logic [W-1:0] div_q,
  output logic         ce
);
  import clk_src_sel_pkg::*;

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = div_wrap(cnt_q, div_q);
  assign ce   = tick && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= W'(1);
      cnt_q <= '0;
    end else if (div_we) begin
      div_q <= div_wdata;
      cnt_q <= '0;
    end else if (tick && div_q != '0) begin
      cnt_q <= wrap ? '0 : cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irc_ce,
  input  logic              sysosc_ce,
  input  logic              wdo_ce,
  input  logic              pllout_ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pll_in_ce,
  output logic              main_ce,
  output logic              sys_ce,
  output logic [1:0]        main_src,
  output logic              pll_src
);
  import clk_src_sel_pkg::*;

  localparam logic [ADDR_W-1:0] A_PLL_SEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PLL_UPD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MAIN_SEL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MAIN_UPD = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DIV      = ADDR_W'(4);

  logic [PLL_SEL_W-1:0]  pll_staged, pll_active;
  logic [MAIN_SEL_W-1:0] main_staged, main_active;
  logic                  pll_upd_q, main_upd_q;
  logic                  pll_commit_w, main_commit_w;
  logic [DATA_W-1:0]     div_q;

  clk_src_stage #(.W(PLL_SEL_W)) u_pll_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (we && addr == A_PLL_SEL),
    .upd_we   (we && addr == A_PLL_UPD),
    .sel_wdata(wdata[PLL_SEL_W-1:0]),
    .upd_wbit (wdata[0]),
    .staged   (pll_staged),
    .active   (pll_active),
    .upd_q    (pll_upd_q),
    .commit   (pll_commit_w)
  );

  clk_src_stage #(.W(MAIN_SEL_W)) u_main_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (we && addr == A_MAIN_SEL),
    .upd_we   (we && addr == A_MAIN_UPD),
    .sel_wdata(wdata[MAIN_SEL_W-1:0]),
    .upd_wbit (wdata[0]),
    .staged   (main_staged),
    .active   (main_active),
    .upd_q    (main_upd_q),
    .commit   (main_commit_w)
  );

  assign pll_in_ce = pick_pll_in(pll_active[0], irc_ce, sysosc_ce);
  assign main_ce   = pick_main(main_active, irc_ce, pll_in_ce, wdo_ce, pllout_ce);
  assign main_src  = main_active;
  assign pll_src   = pll_active[0];

  clk_sys_div #(.W(DATA_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (main_ce),
    .div_we   (we && addr == A_DIV),
    .div_wdata(wdata),
    .div_q    (div_q),
    .ce       (sys_ce)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_PLL_SEL:  rdata = DATA_W'(pll_staged);
      A_PLL_UPD:  rdata = DATA_W'(pll_upd_q);
      A_MAIN_SEL: rdata = DATA_W'(main_staged);
      A_MAIN_UPD: rdata = DATA_W'(main_upd_q);
      A_DIV:      rdata = div_q;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/clk_src_sel_checker.sv
module clk_src_sel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       main_ce,
  input logic       sys_ce,
  input logic [1:0] main_src,
  input logic       pll_src,
  input logic       main_commit,
  input logic       pll_commit,
  input logic       main_upd,
  input logic       pll_upd,
  input logic [7:0] div_val
);

  AST_SYS_NEEDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce |-> main_ce); // R7

  AST_DIV_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == 8'd0) |-> !sys_ce); // R8

  AST_DIV_ONE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == 8'd1) |-> (sys_ce == main_ce)); // R9

  AST_MAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !main_commit |=> $stable(main_src)); // R4

  AST_PLL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_commit |=> $stable(pll_src)); // R4

  AST_MAIN_UPD_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    main_commit |=> main_upd); // R5

  AST_PLL_UPD_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pll_commit |=> pll_upd); // R5

  AST_COMMIT_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    main_commit |-> !main_upd); // R6

endmodule

bind clk_src_sel clk_src_sel_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .main_ce    (main_ce),
  .sys_ce     (sys_ce),
  .main_src   (main_src),
  .pll_src    (pll_src),
  .main_commit(main_commit_w),
  .pll_commit (pll_commit_w),
  .main_upd   (main_upd_q),
  .pll_upd    (pll_upd_q),
  .div_val    (div_q)
);

// File: tb/clk_src_sel_bench.sv
module clk_src_sel_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irc_ce = 1'b0, sysosc_ce = 1'b0, wdo_ce = 1'b0, pllout_ce = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pll_in_ce, main_ce, sys_ce, pll_src;
  logic [1:0] main_src;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  int m_pll_stage, m_pll_act, m_pll_upd;
  int m_main_stage, m_main_act, m_main_upd;
  int m_div, m_seen;
  int sys_pulses;

  always #4 clk = ~clk;

  clk_src_sel u_clk_src_sel (
    .clk(clk), .rst_n(rst_n), .irc_ce(irc_ce), .sysosc_ce(sysosc_ce),
    .wdo_ce(wdo_ce), .pllout_ce(pllout_ce), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pll_in_ce(pll_in_ce), .main_ce(main_ce),
    .sys_ce(sys_ce), .main_src(main_src), .pll_src(pll_src)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pll_stage = 0; m_pll_act = 0; m_pll_upd = 1;
    m_main_stage = 0; m_main_act = 0; m_main_upd = 1;
    m_div = 1; m_seen = 0;
  endtask

  function automatic int exp_pll_in();
    return (m_pll_act == 1) ? int'(sysosc_ce) : int'(irc_ce);
  endfunction

  function automatic int exp_main();
    if (m_main_act == 0) return int'(irc_ce);
    if (m_main_act == 1) return exp_pll_in();
    if (m_main_act == 2) return int'(wdo_ce);
    return int'(pllout_ce);
  endfunction

  function automatic int exp_sys();
    if (m_div == 0) return 0;
    return (exp_main() == 1 && m_seen + 1 == m_div) ? 1 : 0;
  endfunction

  function automatic int exp_read(input int a);
    if (a == 0) return m_pll_stage;
    if (a == 1) return m_pll_upd;
    if (a == 2) return m_main_stage;
    if (a == 3) return m_main_upd;
    if (a == 4) return m_div;
    return 0;
  endfunction

  // one cycle: drive at falling edge, compare, then advance the model at the rising edge
  task automatic step(input bit w, input int a, input int d, input int tick_mask);
    bit mt;
    @(negedge clk);
    we = w; addr = 3'(a); wdata = 8'(d);
    if (tick_mask < 0) begin
      irc_ce = 1'($urandom_range(0, 1)); sysosc_ce = 1'($urandom_range(0, 1));
      wdo_ce = 1'($urandom_range(0, 1)); pllout_ce = 1'($urandom_range(0, 1));
    end else begin
      irc_ce = tick_mask[0]; sysosc_ce = tick_mask[1];
      wdo_ce = tick_mask[2]; pllout_ce = tick_mask[3];
    end
    #1;
    check("R3 pll_in_ce", int'(pll_in_ce), exp_pll_in());
    check("R2 main_ce", int'(main_ce), exp_main());
    check("R7 sys_ce", int'(sys_ce), exp_sys());
    check("R4 main_src", int'(main_src), m_main_act);
    check("R4 pll_src", int'(pll_src), m_pll_act);
    check("R10 rdata", int'(rdata), exp_read(a));
    if (sys_ce) sys_pulses++;
    mt = (exp_main() == 1);
    @(posedge clk);
    if (w && a == 4) begin
      m_div = d & 255; m_seen = 0;
    end else if (mt && m_div != 0) begin
      m_seen = (m_seen + 1 == m_div) ? 0 : m_seen + 1;
    end
    if (w) begin
      case (a)
        0: m_pll_stage = d & 1;
        1: begin if ((d & 1) == 1 && m_pll_upd == 0) m_pll_act = m_pll_stage; m_pll_upd = d & 1; end
        2: m_main_stage = d & 3;
        3: begin if ((d & 1) == 1 && m_main_upd == 0) m_main_act = m_main_stage; m_main_upd = d & 1; end
        default: ;
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, i % 6, 0, -1);
  endtask

  task automatic switch_main(input int code);
    step(1'b1, 2, code, -1);
    step(1'b1, 3, 0, -1);
    step(1'b1, 3, 1, -1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    sys_pulses = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    #1;
    check("R1 main_src reset", int'(main_src), 0);
    check("R1 pll_src reset", int'(pll_src), 0);
    addr = 3'd1; #1 check("R1 pll update reads 1", int'(rdata), 1);
    addr = 3'd3; #1 check("R1 main update reads 1", int'(rdata), 1);
    addr = 3'd4; #1 check("R1 divider reads 1", int'(rdata), 1);
    idle(20);

    // R4 / R6: stage PLL output, lone 1 write must not commit
    step(1'b1, 2, 3, -1);
    idle(5);
    step(1'b1, 3, 1, -1);
    step(1'b0, 3, 0, -1);
    check("R6 main_src after lone 1", int'(main_src), 0);
    // R5: 0 then 1 commits
    step(1'b1, 3, 0, -1);
    step(1'b0, 3, 0, -1);
    check("R5 update reads 0", int'(rdata), 0);
    step(1'b1, 3, 1, -1);
    step(1'b0, 3, 0, -1);
    check("R5 update reads 1", int'(rdata), 1);
    check("R5 main_src now PLL out", int'(main_src), 3);
    idle(20);

    // R2: each main code
    switch_main(2); idle(15);
    switch_main(0); idle(15);

    // R3: PLL input from system oscillator, main from PLL input
    step(1'b1, 0, 1, -1);
    switch_main(1);
    idle(5);
    check("R3 pll_src still RC", int'(pll_src), 0);
    step(1'b1, 1, 0, -1);
    step(1'b1, 1, 1, -1);
    step(1'b0, 0, 0, 4'b0010);
    check("R3 pll_src sysosc", int'(pll_src), 1);
    check("R3 main_ce from sysosc", int'(main_ce), 1);
    idle(20);

    // R9 divide by 1 with a steady tick
    switch_main(0);
    for (int i = 0; i < 10; i++) step(1'b0, 4, 0, 4'b0001);
    check("R9 sys_ce follows main", int'(sys_ce), 1);

    // R7 divide by 3
    step(1'b1, 4, 3, -1);
    sys_pulses = 0;
    for (int i = 0; i < 30; i++) step(1'b0, 4, 0, 4'b0001);
    check("R7 div3 pulse count", sys_pulses, 10);
    idle(40);

    // R8 divider 0
    step(1'b1, 4, 0, -1);
    sys_pulses = 0;
    for (int i = 0; i < 50; i++) step(1'b0, 4, 0, 4'b1111);
    check("R8 div0 no pulses", sys_pulses, 0);

    // R7 divide by 255
    step(1'b1, 4, 255, -1);
    sys_pulses = 0;
    for (int i = 0; i < 510; i++) step(1'b0, 4, 0, 4'b0001);
    check("R7 div255 pulse count", sys_pulses, 2);

    // R10 unmapped addresses read 0
    idle(30);
    step(1'b0, 6, 0, -1);
    check("R10 unmapped read", int'(rdata), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule